// File: doc/BRIEF.md
# Pipeline Operand Bypass and Load-Use Interlock

This block is the hazard controller of a five-stage in-order integer pipeline. It is purely combinational. It watches the register numbers in flight and resolves read-after-write dependences in two ways:

- When the producing value already exists in a later pipeline register, it steers the two ALU operand multiplexers to that register.
- When the producer is a load that sits directly ahead of its consumer, it holds the front of the pipeline for one cycle.

The operand selects look at the EX-stage instruction's sources. They compare them against the destinations held in the EX/MEM and MEM/WB registers. The interlock looks at the ID-stage instruction's sources and compares them against the ID/EX destination when that instruction is a load.

During an interlock cycle the consumer stays in ID and its successor stays in IF. A no-op is loaded into ID/EX. One cycle later the load's data sits in MEM/WB, and ordinary bypassing serves the consumer.

The register file writes in the first half of a cycle and reads in the second half. A write-back therefore needs no third bypass path and no stall. Only read-after-write dependences are handled: reads always occur in stage 2 and writes in stage 5, so write-after-read and write-after-write ordering is preserved.

Top module: `fwd_hazard_unit`

## Requirements
- R1: An operand select is 2'b10 (EX/MEM) when the EX/MEM write-enable is high, its destination is nonzero, and the destination equals that operand's EX-stage source.
- R2: An operand select is 2'b01 (MEM/WB) when MEM/WB writes a nonzero destination equal to that source, and R1 does not apply to that operand.
- R3: When EX/MEM and MEM/WB both match the same source, the select is 2'b10.
- R4: Register 0 never produces a nonzero select and never raises the stall, whatever the destinations and enables are.
- R5: A destination whose write-enable is low never produces a forward or a stall, even when its register number matches.
- R6: With no qualifying match, a select is 2'b00 (register file); the value 2'b11 never appears.
- R7: The stall is high exactly when ID/EX holds a load with write-enable high and a nonzero destination equal to either ID-stage source.
- R8: The bubble output equals the stall output in every cycle.
- R9: An ID-stage source that matches only a non-load ID/EX destination, the EX/MEM destination or the MEM/WB destination raises no stall.
- R10: The two operand selects are decided independently, each from its own source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1_i | input | REG_AW | First source register of the instruction in ID |
| id_rs2_i | input | REG_AW | Second source register of the instruction in ID |
| ex_rs1_i | input | REG_AW | First source register of the instruction in EX |
| ex_rs2_i | input | REG_AW | Second source register of the instruction in EX |
| idex_rd_i | input | REG_AW | Destination held in ID/EX |
| idex_we_i | input | 1 | Register write-enable held in ID/EX |
| idex_load_i | input | 1 | ID/EX instruction is a load |
| exmem_rd_i | input | REG_AW | Destination held in EX/MEM |
| exmem_we_i | input | 1 | Register write-enable held in EX/MEM |
| memwb_rd_i | input | REG_AW | Destination held in MEM/WB |
| memwb_we_i | input | 1 | Register write-enable held in MEM/WB |
| fwd_a_o | output | 2 | First ALU operand select (00 file, 10 EX/MEM, 01 MEM/WB) |
| fwd_b_o | output | 2 | Second ALU operand select, same encoding |
| stall_o | output | 1 | Freeze PC and IF/ID |
| bubble_o | output | 1 | Load a no-op into ID/EX |

## Verification
The bench sweeps every combination of one source, both bypass destinations and both write-enables on a 3-bit register space. This exposes a design that puts MEM/WB ahead of EX/MEM and so hands the consumer a stale value. It also exposes one that bypasses register 0 or a disabled write, which corrupts operands with bubble contents.

A second sweep covers both ID sources against every ID/EX destination, with and without the load and write flags. It catches an interlock that ignores the second source or fires on ALU producers, which would lose throughput. It also catches one that fires on register 0, or lets the bubble drift apart from the stall, which would duplicate or drop an instruction.

// File: rtl/fwd_hazard_pkg.sv
package fwd_hazard_pkg;
  typedef enum logic [1:0] {
    FWD_RF    = 2'b00,
    FWD_MEMWB = 2'b01,
    FWD_EXMEM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/fwd_src_match.sv
module fwd_src_match #(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] src_i,
  input  logic [REG_AW-1:0] rd_i,
  input  logic              we_i,
  output logic              hit_o
);
  localparam logic [REG_AW-1:0] ZERO_REG = '0;
  // x0 is hardwired; a write to it carries no data
  assign hit_o = we_i && (rd_i != ZERO_REG) && (rd_i == src_i);
endmodule

// File: rtl/fwd_operand_sel.sv
module fwd_operand_sel
  import fwd_hazard_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] src_i,
  input  logic [REG_AW-1:0] exmem_rd_i,
  input  logic              exmem_we_i,
  input  logic [REG_AW-1:0] memwb_rd_i,
  input  logic              memwb_we_i,
  output logic [1:0]        sel_o
);
  logic exmem_hit, memwb_hit;
  fwd_sel_e sel;

  fwd_src_match #(.REG_AW(REG_AW)) u_m_exmem (
    .src_i(src_i), .rd_i(exmem_rd_i), .we_i(exmem_we_i), .hit_o(exmem_hit));
  fwd_src_match #(.REG_AW(REG_AW)) u_m_memwb (
    .src_i(src_i), .rd_i(memwb_rd_i), .we_i(memwb_we_i), .hit_o(memwb_hit));

  // younger producer wins
  always_comb begin
    if (exmem_hit)      sel = FWD_EXMEM;
    else if (memwb_hit) sel = FWD_MEMWB;
    else                sel = FWD_RF;
  end

  assign sel_o = sel;
endmodule

// File: rtl/load_use_detect.sv
module load_use_detect #(
  parameter int REG_AW  = 5,
  parameter int NUM_SRC = 2
) (
  input  logic [NUM_SRC-1:0][REG_AW-1:0] id_src_i,
  input  logic [REG_AW-1:0]              idex_rd_i,
  input  logic                           idex_we_i,
  input  logic                           idex_load_i,
  output logic                           stall_o
);
  logic [NUM_SRC-1:0] hit;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    fwd_src_match #(.REG_AW(REG_AW)) u_m (
      .src_i(id_src_i[g]), .rd_i(idex_rd_i), .we_i(idex_we_i), .hit_o(hit[g]));
  end

  assign stall_o = idex_load_i && (|hit);
endmodule

// File: rtl/fwd_hazard_unit.sv
module fwd_hazard_unit #(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] id_rs1_i,
  input  logic [REG_AW-1:0] id_rs2_i,
  input  logic [REG_AW-1:0] ex_rs1_i,
  input  logic [REG_AW-1:0] ex_rs2_i,
  input  logic [REG_AW-1:0] idex_rd_i,
  input  logic              idex_we_i,
  input  logic              idex_load_i,
  input  logic [REG_AW-1:0] exmem_rd_i,
  input  logic              exmem_we_i,
  input  logic [REG_AW-1:0] memwb_rd_i,
  input  logic              memwb_we_i,
  output logic [1:0]        fwd_a_o,
  output logic [1:0]        fwd_b_o,
  output logic              stall_o,
  output logic              bubble_o
);
  localparam int NUM_SRC = 2;

  logic [NUM_SRC-1:0][REG_AW-1:0] ex_src;
  logic [NUM_SRC-1:0][REG_AW-1:0] id_src;
  logic [NUM_SRC-1:0][1:0]        sel;
  logic                           lu_stall;

  assign ex_src = {ex_rs2_i, ex_rs1_i};
  assign id_src = {id_rs2_i, id_rs1_i};

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_opnd
    fwd_operand_sel #(.REG_AW(REG_AW)) u_sel (
      .src_i      (ex_src[g]),
      .exmem_rd_i (exmem_rd_i),
      .exmem_we_i (exmem_we_i),
      .memwb_rd_i (memwb_rd_i),
      .memwb_we_i (memwb_we_i),
      .sel_o      (sel[g])
    );
  end

  // split-phase file: WB write is visible to ID read, no ID-side bypass
  load_use_detect #(.REG_AW(REG_AW), .NUM_SRC(NUM_SRC)) u_lu (
    .id_src_i    (id_src),
    .idex_rd_i   (idex_rd_i),
    .idex_we_i   (idex_we_i),
    .idex_load_i (idex_load_i),
    .stall_o     (lu_stall)
  );

  assign fwd_a_o  = sel[0];
  assign fwd_b_o  = sel[1];
  assign stall_o  = lu_stall;
  assign bubble_o = lu_stall;
endmodule

// File: rtl/fwd_hazard_chk.sv
module fwd_hazard_chk #(
  parameter int REG_AW = 5
) (
  input logic [REG_AW-1:0] id_rs1_i,
  input logic [REG_AW-1:0] id_rs2_i,
  input logic [REG_AW-1:0] ex_rs1_i,
  input logic [REG_AW-1:0] ex_rs2_i,
  input logic [REG_AW-1:0] idex_rd_i,
  input logic              idex_we_i,
  input logic              idex_load_i,
  input logic [REG_AW-1:0] exmem_rd_i,
  input logic              exmem_we_i,
  input logic [REG_AW-1:0] memwb_rd_i,
  input logic              memwb_we_i,
  input logic [1:0]        fwd_a_o,
  input logic [1:0]        fwd_b_o,
  input logic              stall_o,
  input logic              bubble_o
);
  always_comb begin
    a_r6_sel_legal: assert (fwd_a_o != 2'b11 && fwd_b_o != 2'b11)
      else $error("illegal forward select");
    a_r4_zero_no_fwd: assert ((ex_rs1_i != '0 || fwd_a_o == 2'b00) &&
                              (ex_rs2_i != '0 || fwd_b_o == 2'b00))
      else $error("register 0 forwarded");
    a_r4_zero_no_stall: assert (!stall_o || idex_rd_i != '0)
      else $error("stall on register 0");
    a_r5_exmem_we: assert ((fwd_a_o != 2'b10 && fwd_b_o != 2'b10) || exmem_we_i)
      else $error("EX/MEM forward without write-enable");
    a_r5_memwb_we: assert ((fwd_a_o != 2'b01 && fwd_b_o != 2'b01) || memwb_we_i)
      else $error("MEM/WB forward without write-enable");
    a_r3_exmem_first: assert (!(exmem_we_i && exmem_rd_i != '0 && exmem_rd_i == ex_rs1_i)
                              || fwd_a_o == 2'b10)
      else $error("EX/MEM priority lost");
    a_r7_stall_on_load: assert (!stall_o || (idex_load_i && idex_we_i &&
                                (idex_rd_i == id_rs1_i || idex_rd_i == id_rs2_i)))
      else $error("stall without load dependence");
    a_r8_bubble_eq: assert (bubble_o == stall_o)
      else $error("bubble and stall differ");
  end
endmodule

bind fwd_hazard_unit fwd_hazard_chk #(.REG_AW(REG_AW)) u_chk (.*);

// File: tb/fwd_hazard_unit_tb.sv
module fwd_hazard_unit_tb;
  localparam int AW = 3;
  localparam int NR = 1 << AW;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic [AW-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, idex_rd, exmem_rd, memwb_rd;
  logic idex_we, idex_load, exmem_we, memwb_we;
  logic [1:0] fwd_a, fwd_b;
  logic stall, bubble;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  fwd_hazard_unit #(.REG_AW(AW)) u_dut (
    .id_rs1_i(id_rs1), .id_rs2_i(id_rs2), .ex_rs1_i(ex_rs1), .ex_rs2_i(ex_rs2),
    .idex_rd_i(idex_rd), .idex_we_i(idex_we), .idex_load_i(idex_load),
    .exmem_rd_i(exmem_rd), .exmem_we_i(exmem_we),
    .memwb_rd_i(memwb_rd), .memwb_we_i(memwb_we),
    .fwd_a_o(fwd_a), .fwd_b_o(fwd_b), .stall_o(stall), .bubble_o(bubble));

  task automatic chk(input string tag, input logic [1:0] got, input logic [1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  function automatic logic [1:0] exp_sel(input int s, input int er, input int ew,
                                         input int mr, input int mw);
    if (ew != 0 && er != 0 && er == s)      return 2'b10;
    else if (mw != 0 && mr != 0 && mr == s) return 2'b01;
    else                                    return 2'b00;
  endfunction

  function automatic string sel_tag(input int s, input int er, input int ew,
                                    input int mr, input int mw);
    bit eh = (ew != 0 && er != 0 && er == s);
    bit mh = (mw != 0 && mr != 0 && mr == s);
    if (s == 0)                                          return "R4";
    if (eh && mh)                                        return "R3";
    if (eh)                                              return "R1";
    if (mh)                                              return "R2";
    if ((er == s && ew == 0) || (mr == s && mw == 0))    return "R5";
    return "R6";
  endfunction

  initial begin
    {id_rs1, id_rs2, ex_rs1, ex_rs2, idex_rd, exmem_rd, memwb_rd} = '0;
    {idex_we, idex_load, exmem_we, memwb_we} = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    // reset / idle state
    chk("R6 idle fwd_a", fwd_a, 2'b00);
    chk("R6 idle fwd_b", fwd_b, 2'b00);
    chk("R7 idle stall", {1'b0, stall}, 2'b00);

    // sweep 1: bypass selects
    for (int s = 0; s < NR; s++)
      for (int er = 0; er < NR; er++)
        for (int ew = 0; ew < 2; ew++)
          for (int mr = 0; mr < NR; mr++)
            for (int mw = 0; mw < 2; mw++) begin
              int s2;
              s2 = (s + 3) % NR;
              @(negedge clk);
              ex_rs1 = AW'(s); ex_rs2 = AW'(s2);
              exmem_rd = AW'(er); exmem_we = ew[0];
              memwb_rd = AW'(mr); memwb_we = mw[0];
              id_rs1 = AW'(s); id_rs2 = AW'(s2);
              idex_rd = AW'(s); idex_load = 1'b1; idex_we = 1'b0;
              #1;
              chk(sel_tag(s, er, ew, mr, mw), fwd_a, exp_sel(s, er, ew, mr, mw));
              chk("R10 operand b", fwd_b, exp_sel(s2, er, ew, mr, mw));
              chk("R5 load without we", {1'b0, stall}, 2'b00);
            end

    // sweep 2: load-use interlock
    for (int a = 0; a < NR; a++)
      for (int b = 0; b < NR; b++)
        for (int r = 0; r < NR; r++)
          for (int w = 0; w < 2; w++)
            for (int l = 0; l < 2; l++) begin
              bit e;
              string t;
              @(negedge clk);
              id_rs1 = AW'(a); id_rs2 = AW'(b);
              idex_rd = AW'(r); idex_we = w[0]; idex_load = l[0];
              exmem_rd = AW'(a); exmem_we = 1'b1;
              memwb_rd = AW'(b); memwb_we = 1'b1;
              ex_rs1 = '0; ex_rs2 = '0;
              #1;
              e = (l != 0) && (w != 0) && (r != 0) && (r == a || r == b);
              if (r == 0) t = "R4 stall";
              else if (e) t = "R7 stall";
              else if (w == 0 && (r == a || r == b)) t = "R5 stall";
              else t = "R9 stall";
              chk(t, {1'b0, stall}, {1'b0, e});
              chk("R8 bubble", {1'b0, bubble}, {1'b0, e});
            end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end
endmodule